// File: doc/BRIEF.md
# Decimal Stopwatch Count Chain with Lap Hold

This block is the counting core of a stopwatch. A free-running system clock drives it, and a one-cycle `tick` pulse arrives once per millisecond as a clock enable. Five decimal digits are held in packed BCD form. Together they form a 20-bit count, and the ones digit sits in bits 3:0. While `run` is high, each tick advances this count by one. A `clr` input zeroes the count, and it wins over counting.

A separate 16-bit hold register drives a bank of 16 LEDs. It takes a copy of the four low digits when `xfer` is high. While `xfer` is low it keeps its old value. A control machine outside the block can use this to freeze a lap time on the LEDs while the count keeps moving. Debounce, that control machine and display multiplexing are outside this block. Every input is a plain level or strobe, and there is no back-pressure. The count has no flow control and the block never stalls.

Top module: `stopwatch_bcd_core`

## Requirements
- R1: A synchronous active-high `rst` sets `count_o` and `leds_o` to zero on the next rising edge, whatever the other inputs are.
- R2: When `tick` and `run` are high and `clr` is low, the count after the edge is the decimal value before the edge plus one, still in packed BCD with digit k in bits 4k+3:4k.
- R3: A digit that holds 9 when it is stepped becomes 0 and steps the next higher digit; for example, 00009 becomes 00010 and 00999 becomes 01000.
- R4: When `tick` or `run` is low and `clr` is low, the count keeps its value.
- R5: From 99999, one counting tick gives 00000.
- R6: When `clr` is high, the count is zero after the edge, whatever `tick` and `run` are.
- R7: When `xfer` is high, `leds_o` takes `count_o[15:0]` as it stood before the edge. When `xfer` is low, `leds_o` keeps its value.
- R8: When `clr` and `xfer` are both high in the same cycle, `leds_o` captures the count from before the clear.
- R9: Every 4-bit digit of `count_o` stays in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle count-enable pulse at the 1 kHz rate |
| run | input | 1 | Count permission; when low, the count holds |
| clr | input | 1 | Zero the count; takes priority over counting |
| xfer | input | 1 | Copy the low four digits into the LED hold register |
| count_o | output | 20 | Full five-digit packed BCD count |
| leds_o | output | 16 | Held copy of the low four digits, drives the LEDs |

## Verification
A long directed run ticks on every cycle from zero up to 99999 and then one step past it. This run exercises every digit carry and the full wrap, which random stimulus would almost never reach. Random cycles then mix sparse and dense ticks with `run` dropping out. This separates a counter that steps on `tick` alone from one that also obeys `run`. Rare clears and frequent transfers give the simultaneous clear-and-transfer case. That case separates a hold register that samples before the clear from one that samples after it. A mid-run reset ends the sequence.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
  import sw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step_in,
  output bcd_t val_o,
  output logic at_top_o
);
  bcd_t q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (step_in) begin
      q <= (q == BCD_TOP) ? '0 : q + bcd_t'(1);
    end
  end

  assign val_o    = q;
  assign at_top_o = (q == BCD_TOP);
endmodule

// File: rtl/sw_lap_latch.sv
module sw_lap_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/stopwatch_bcd_core.sv
module stopwatch_bcd_core
  import sw_pkg::*;
#(
  parameter int DIGITS = 5,
  parameter int SHOWN  = 4,
  localparam int CW = DIGITS * DIGIT_W,
  localparam int LW = SHOWN * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          clr,
  input  logic          xfer,
  output logic [CW-1:0] count_o,
  output logic [LW-1:0] leds_o
);
  // step[k] is high when digit k advances this cycle
  logic [DIGITS:0]   step;
  logic [DIGITS-1:0] top;

  assign step[0] = tick & run;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    sw_bcd_digit u_dig (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .step_in  (step[k]),
      .val_o    (count_o[k*DIGIT_W +: DIGIT_W]),
      .at_top_o (top[k])
    );
    assign step[k+1] = step[k] & top[k];
  end

  // latch samples the register outputs, so a same-cycle clear is not seen
  sw_lap_latch #(.W(LW)) u_lap (
    .clk  (clk),
    .rst  (rst),
    .load (xfer),
    .d    (count_o[LW-1:0]),
    .q    (leds_o)
  );
endmodule

// File: rtl/sw_core_checker.sv
module sw_core_checker #(
  parameter int DIGITS = 5,
  parameter int SHOWN  = 4,
  localparam int CW = DIGITS * 4,
  localparam int LW = SHOWN * 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          run,
  input logic          clr,
  input logic          xfer,
  input logic [CW-1:0] count_o,
  input logic [LW-1:0] leds_o
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && leds_o == '0));

  assert_step_moves_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !clr) |=> (count_o != $past(count_o)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((!tick || !run) && !clr) |=> $stable(count_o));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_o == '0));

  // also covers R8: past count is the pre-clear value
  assert_lap_load_R7: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (leds_o == $past(count_o[LW-1:0])));

  assert_lap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(leds_o));

  for (genvar k = 0; k < DIGITS; k++) begin : g_rng
    assert_digit_range_R9: assert property (@(posedge clk) disable iff (rst)
      count_o[k*4 +: 4] <= 4'd9);
  end
endmodule

bind stopwatch_bcd_core sw_core_checker #(.DIGITS(DIGITS), .SHOWN(SHOWN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .run     (run),
  .clr     (clr),
  .xfer    (xfer),
  .count_o (count_o),
  .leds_o  (leds_o)
);

// File: tb/stopwatch_bcd_core_tb.sv
module stopwatch_bcd_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic        clk = 0;
  logic        rst, tick, run, clr, xfer;
  logic [19:0] count_o;
  logic [15:0] leds_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int m_val  = 0;      // decimal model of the count
  logic [15:0] m_lap = '0;

  stopwatch_bcd_core u_dut (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .clr(clr), .xfer(xfer),
    .count_o(count_o), .leds_o(leds_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  function automatic logic [19:0] to_bcd(input int v);
    logic [19:0] r;
    int t;
    t = v;
    for (int k = 0; k < 5; k++) begin
      r[k*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns after the next falling edge
  task automatic apply(input logic r, input logic t, input logic rn, input logic c,
                       input logic x, input bit do_chk, input string ctag, input string ltag);
    rst = r; tick = t; run = rn; clr = c; xfer = x;
    @(posedge clk);
    if (r) begin
      m_val = 0; m_lap = '0;
    end else begin
      if (x) m_lap = to_bcd(m_val)[15:0];
      if (c) m_val = 0;
      else if (t && rn) m_val = (m_val + 1) % 100000;
    end
    @(negedge clk);
    if (do_chk) begin
      check(ctag, count_o, to_bcd(m_val));
      check(ltag, {4'd0, leds_o}, {4'd0, m_lap});
    end
  endtask

  initial begin
    @(negedge clk);
    apply(1, 1, 1, 0, 1, 0, "R1", "R1");
    apply(1, 1, 1, 0, 1, 0, "R1", "R1");
    apply(1, 0, 0, 0, 0, 1, "R1", "R1");
    // counting: 0..9 then carry into tens
    for (int i = 0; i < 9; i++) apply(0, 1, 1, 0, 0, 1, "R2", "R7");
    check("R2", count_o, 20'h00009);
    apply(0, 1, 1, 0, 0, 1, "R3", "R7");
    check("R3", count_o, 20'h00010);
    apply(0, 1, 0, 0, 0, 1, "R4", "R7");
    apply(0, 0, 1, 0, 1, 1, "R4", "R7");
    check("R7", {4'd0, leds_o}, 20'h00010);
    for (int i = 0; i < 989; i++) apply(0, 1, 1, 0, 0, 0, "R3", "R7");
    check("R3", count_o, 20'h00999);
    apply(0, 1, 1, 0, 0, 1, "R3", "R7");
    check("R3", count_o, 20'h01000);
    // clear plus transfer together: lap gets pre-clear value
    apply(0, 1, 1, 1, 1, 1, "R6", "R8");
    check("R8", {4'd0, leds_o}, 20'h01000);
    check("R6", count_o, 20'h00000);
    // full range then wrap
    for (int i = 0; i < 99999; i++) apply(0, 1, 1, 0, 0, 0, "R5", "R7");
    check("R5", count_o, 20'h99999);
    apply(0, 1, 1, 0, 1, 1, "R5", "R7");
    check("R5", count_o, 20'h00000);
    check("R7", {4'd0, leds_o}, 20'h09999);
    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic t, rn, c, x;
      string ct, lt;
      t  = ($urandom % 2) == 0;
      rn = ($urandom % 4) != 0;
      c  = ($urandom % 32) == 0;
      x  = ($urandom % 4) == 0;
      ct = c ? "R6" : ((t && rn) ? "R2" : "R4");
      lt = (c && x) ? "R8" : "R7";
      apply(0, t, rn, c, x, 1, ct, lt);
      for (int k = 0; k < 5; k++) begin
        checks++;
        if (count_o[k*4 +: 4] > 4'd9) begin
          errors++;
          $display("FAIL R9: actual digit %0d = %h expected <= 9", k, count_o[k*4 +: 4]);
        end
      end
    end
    // reset in the middle of activity
    apply(1, 1, 1, 0, 1, 1, "R1", "R1");
    check("R1", count_o, 20'h0);
    check("R1", {4'd0, leds_o}, 20'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule